// File: doc/BRIEF.md
# Redirection-Table Interrupt Router

This block gathers a set of interrupt lines and sends each active line out through a programmable redirection entry. Each entry holds a vector, a destination ID, a destination addressing mode, a delivery mode, a trigger mode, a polarity and a mask. A single delivery port issues one interrupt at a time. The port carries the entry's fields together with the pin number and uses a valid/ready handshake.

Software reaches the block through two 32-bit words. The word at byte offset 0x00 selects an internal register. The word at offset 0x10 is a window onto the selected register. The internal registers are an ID register, a read-only version register, a read-only arbitration alias of the ID, and a 64-bit entry per pin that is reached as two 32-bit halves.

Entries set to level trigger carry a remote-pending flag. The flag holds back redelivery until an end-of-interrupt (EOI) notice arrives for the entry's vector. One EOI is matched by vector against every entry. A line that is still active when its entry is acknowledged or unmasked is sent again.

Top module: `irq_redir_router`

## Requirements
- R1: Offset 0x00 is the index register (8 bits, reads back zero-extended). Offset 0x10 is the data window. Any other offset reads 0 and ignores writes. A write whose byte length is neither 4 nor 8 changes nothing.
- R2: Index 0x01 reads {8'h00, pin count − 1, 8'h00, version code 0x11}, which is 0x00170011 for 24 pins. Writes to it are ignored.
- R3: Index 0x00 holds a 4-bit ID in bits 27:24, and only those bits are writable. Index 0x02 reads the same value. Writes to index 0x02 are ignored.
- R4: Index 0x10 + 2n selects the lower half of entry n, and 0x11 + 2n selects the upper half. The lower half holds vector [7:0], delivery mode [10:8], logical-destination flag [11], polarity [13], remote-pending [14] (read-only), trigger [15] (1 = level) and mask [16]. The upper half holds the destination [31:24]. Every other bit reads 0. Indices whose entry number is at or above the pin count read 0 and ignore writes.
- R5: A pin's request equals its line XOR the entry's polarity bit.
- R6: An edge-triggered pin produces exactly one delivery for each 0-to-1 change of its request. A request that stays high produces nothing more.
- R7: A level-triggered pin is delivered while its request is high and its remote-pending bit is clear. The delivery sets remote-pending, which blocks any further delivery.
- R8: A masked pin is never delivered. An edge arriving while the pin is masked is dropped. A level pin that is still active is delivered once it is unmasked.
- R9: A level-type EOI for vector V clears remote-pending in every entry whose vector is V. Each such entry is delivered again if its request is still high and it is unmasked. An edge-type EOI has no effect.
- R10: Writing the lower half of an entry clears its remote-pending bit. Writing the upper half leaves the bit unchanged.
- R11: The delivery port presents pin, vector, destination, logical flag, delivery mode and trigger. The port holds all of these stable while valid is high and ready is low.
- R12: When several pins need service together, the lowest-numbered pin goes first.
- R13: After reset, every entry is masked with all other fields zero. The index, the ID and all requests are zero, and the port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Byte offset of the access |
| reg_len_i | input | 4 | Access length in bytes |
| reg_wdata_i | input | 32 | Write data (low word) |
| reg_rdata_o | output | 32 | Read data, combinational |
| irq_i | input | NPINS | Interrupt lines |
| eoi_valid_i | input | 1 | EOI notice strobe |
| eoi_level_i | input | 1 | EOI is level-type |
| eoi_vec_i | input | 8 | Vector being acknowledged |
| dlv_valid_o | output | 1 | Delivery valid |
| dlv_ready_i | input | 1 | Delivery accepted |
| dlv_pin_o | output | PIN_W | Source pin |
| dlv_vec_o | output | 8 | Vector |
| dlv_dest_o | output | 8 | Destination ID |
| dlv_dst_logical_o | output | 1 | Logical destination flag |
| dlv_dmode_o | output | 3 | Delivery mode |
| dlv_level_o | output | 1 | Trigger mode, 1 = level |

## Verification
The bench targets the following corner cases and the failure each one would expose:

- **Held edge line.** An edge line is held high. A design that treats the request as a level would deliver repeatedly.
- **Polarity reprogramming.** An inverted-polarity entry is programmed while its line is low. A design that ignores the XOR would miss the delivery this causes, or would deliver on the wrong line transition.
- **Remote-pending flag.** The bench checks that the flag blocks a held level line, that it survives an upper-half write, and that it clears on a lower-half write or on a level-type EOI. A mistake here shows up as a storm of deliveries or as a lost one.
- **Shared vector and stalled port.** Two level pins share one vector and raise together while the port is stalled. The bench then expects the payload to stay stable, the lower pin to go first, and a single EOI to release both pins.
- **Masking.** A line that rises while masked must stay silent for edge trigger and must be delivered for level trigger.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       pol;
    logic       dst_logical;
    logic [2:0] dmode;
    logic [7:0] vec;
  } redir_ent_t;

  localparam redir_ent_t ENT_RST = '{dest: 8'h00, mask: 1'b1, level: 1'b0, pol: 1'b0,
                                     dst_logical: 1'b0, dmode: 3'h0, vec: 8'h00};

  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam logic [7:0] IDX_ID  = 8'h00;
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_ARB = 8'h02;
  localparam logic [7:0] IDX_TBL = 8'h10;

  function automatic logic [31:0] ent_lo(redir_ent_t e, logic rem);
    logic [31:0] w;
    w        = '0;
    w[7:0]   = e.vec;
    w[10:8]  = e.dmode;
    w[11]    = e.dst_logical;
    w[13]    = e.pol;
    w[14]    = rem;
    w[15]    = e.level;
    w[16]    = e.mask;
    return w;
  endfunction

  function automatic logic [31:0] ent_hi(redir_ent_t e);
    return {e.dest, 24'h000000};
  endfunction

  function automatic redir_ent_t put_lo(redir_ent_t e, logic [31:0] d);
    redir_ent_t r;
    r             = e;
    r.vec         = d[7:0];
    r.dmode       = d[10:8];
    r.dst_logical = d[11];
    r.pol         = d[13];
    r.level       = d[15];
    r.mask        = d[16];
    return r;
  endfunction

  function automatic redir_ent_t put_hi(redir_ent_t e, logic [31:0] d);
    redir_ent_t r;
    r      = e;
    r.dest = d[31:24];
    return r;
  endfunction

endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int unsigned NPINS   = 24,
  parameter logic [7:0]  VERSION = 8'h11,
  localparam int unsigned PIN_W  = $clog2(NPINS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [7:0]              addr_i,
  input  logic [3:0]              len_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  logic [NPINS-1:0]        remote_i,
  output redir_ent_t [NPINS-1:0]  ent_o,
  output logic [NPINS-1:0]        lo_wr_o
);

  logic [7:0] idx_q;
  logic [3:0] id_q;
  logic [6:0] ent_num;
  logic [PIN_W-1:0] ent_sel;
  logic len_ok, wr_ok, sel_wr, win_wr, tbl_idx, tbl_hit;
  logic [31:0] win_rd;

  assign len_ok  = (len_i == 4'd4) || (len_i == 4'd8);
  assign wr_ok   = req_i & we_i & len_ok;
  assign sel_wr  = wr_ok && (addr_i == OFS_SEL);
  assign win_wr  = wr_ok && (addr_i == OFS_WIN);
  assign ent_num = 7'((idx_q - IDX_TBL) >> 1);
  assign ent_sel = ent_num[PIN_W-1:0];
  assign tbl_idx = idx_q >= IDX_TBL;
  assign tbl_hit = tbl_idx && (32'(ent_num) < NPINS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr) idx_q <= wdata_i[7:0];
      if (win_wr && idx_q == IDX_ID) id_q <= wdata_i[27:24];
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    redir_ent_t e_q;
    logic hit;
    assign hit        = win_wr && tbl_hit && (32'(ent_num) == g);
    assign lo_wr_o[g] = hit & ~idx_q[0];
    assign ent_o[g]   = e_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  e_q <= ENT_RST;
      else if (hit) e_q <= idx_q[0] ? put_hi(e_q, wdata_i) : put_lo(e_q, wdata_i);
    end
  end

  always_comb begin
    win_rd = '0;
    if (idx_q == IDX_VER)
      win_rd = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};
    else if (idx_q == IDX_ID || idx_q == IDX_ARB)
      win_rd = {4'h0, id_q, 24'h000000};
    else if (tbl_hit)
      win_rd = idx_q[0] ? ent_hi(ent_o[ent_sel]) : ent_lo(ent_o[ent_sel], remote_i[ent_sel]);
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (addr_i == OFS_SEL)      rdata_o = {24'h000000, idx_q};
      else if (addr_i == OFS_WIN) rdata_o = win_rd;
    end
  end

  p_bad_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !len_ok) |=> ($stable(idx_q) && $stable(ent_o) && $stable(id_q)));

  p_arb_ro_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_wr && idx_q == IDX_ARB) |=> $stable(id_q));

  p_oob_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_wr && tbl_idx && !tbl_hit) |=> $stable(ent_o));

endmodule

// File: rtl/irq_redir_pins.sv
module irq_redir_pins #(
  parameter int unsigned NPINS = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] lines_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] level_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic [7:0]       vec_i [NPINS],
  input  logic [NPINS-1:0] lo_wr_i,
  input  logic             eoi_valid_i,
  input  logic             eoi_level_i,
  input  logic [7:0]       eoi_vec_i,
  input  logic [NPINS-1:0] launch_i,
  output logic [NPINS-1:0] svc_o,
  output logic [NPINS-1:0] remote_o
);

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic req_q, svc_q, rem_q;
    logic req_d, want, eoi_hit, svc_d;

    assign req_d   = lines_i[g] ^ pol_i[g];
    assign want    = level_i[g] ? (req_d & ~rem_q) : (req_d & ~req_q);
    assign eoi_hit = eoi_valid_i & eoi_level_i & (vec_i[g] == eoi_vec_i);
    // level service tracks the live request; edge service is sticky until launched
    assign svc_d   = (level_i[g] ? want : (svc_q | want)) & ~mask_i[g] & ~launch_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q <= 1'b0;
        svc_q <= 1'b0;
        rem_q <= 1'b0;
      end else begin
        req_q <= req_d;
        svc_q <= svc_d;
        if (launch_i[g] && level_i[g]) rem_q <= 1'b1;
        else if (eoi_hit || lo_wr_i[g]) rem_q <= 1'b0;
      end
    end

    assign svc_o[g]    = svc_q;
    assign remote_o[g] = rem_q;

    p_rem_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (launch_i[g] && level_i[g]) |=> rem_q);

    p_eoi_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoi_hit && !launch_i[g]) |=> !rem_q);

    p_lo_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lo_wr_i[g] && !launch_i[g]) |=> !rem_q);
  end

endmodule

// File: rtl/irq_redir_out.sv
module irq_redir_out
  import irq_redir_pkg::*;
#(
  parameter int unsigned NPINS  = 24,
  localparam int unsigned PIN_W = $clog2(NPINS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NPINS-1:0]       svc_i,
  input  logic [NPINS-1:0]       mask_i,
  input  redir_ent_t [NPINS-1:0] ent_i,
  input  logic                   ready_i,
  output logic [NPINS-1:0]       launch_o,
  output logic                   valid_o,
  output logic [PIN_W-1:0]       pin_o,
  output redir_ent_t             ent_o
);

  logic [NPINS-1:0] cand;
  logic [PIN_W-1:0] pick;
  logic found, free, fire;
  logic valid_q;
  logic [PIN_W-1:0] pin_q;
  redir_ent_t ent_q;

  assign cand = svc_i & ~mask_i;

  always_comb begin
    pick = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (cand[i]) pick = PIN_W'(i);
  end

  assign found    = |cand;
  assign free     = ~valid_q | ready_i;
  assign fire     = found & free;
  assign launch_o = fire ? (NPINS'(1) << pick) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pin_q   <= '0;
      ent_q   <= '0;
    end else if (free) begin
      valid_q <= found;
      if (found) begin
        pin_q <= pick;
        ent_q <= ent_i[pick];
      end
    end
  end

  assign valid_o = valid_q;
  assign pin_o   = pin_q;
  assign ent_o   = ent_q;

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(pin_q) && $stable(ent_q)));

  p_one_launch_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(launch_o));

  p_no_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_o & mask_i) == '0);

endmodule

// File: rtl/irq_redir_router.sv
module irq_redir_router
  import irq_redir_pkg::*;
#(
  parameter int unsigned NPINS   = 24,
  parameter logic [7:0]  VERSION = 8'h11,
  localparam int unsigned PIN_W  = $clog2(NPINS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_req_i,
  input  logic             reg_we_i,
  input  logic [7:0]       reg_addr_i,
  input  logic [3:0]       reg_len_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic [NPINS-1:0] irq_i,
  input  logic             eoi_valid_i,
  input  logic             eoi_level_i,
  input  logic [7:0]       eoi_vec_i,
  output logic             dlv_valid_o,
  input  logic             dlv_ready_i,
  output logic [PIN_W-1:0] dlv_pin_o,
  output logic [7:0]       dlv_vec_o,
  output logic [7:0]       dlv_dest_o,
  output logic             dlv_dst_logical_o,
  output logic [2:0]       dlv_dmode_o,
  output logic             dlv_level_o
);

  redir_ent_t [NPINS-1:0] ent;
  redir_ent_t out_ent;
  logic [NPINS-1:0] lo_wr, remote, svc, launch, pol, level, mask;
  logic [7:0] vec [NPINS];

  for (genvar g = 0; g < NPINS; g++) begin : g_fld
    assign pol[g]   = ent[g].pol;
    assign level[g] = ent[g].level;
    assign mask[g]  = ent[g].mask;
    assign vec[g]   = ent[g].vec;
  end

  irq_redir_regs #(.NPINS(NPINS), .VERSION(VERSION)) i_regs (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i), .len_i(reg_len_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .remote_i(remote), .ent_o(ent), .lo_wr_o(lo_wr)
  );

  irq_redir_pins #(.NPINS(NPINS)) i_pins (
    .clk_i, .rst_ni,
    .lines_i(irq_i), .pol_i(pol), .level_i(level), .mask_i(mask), .vec_i(vec),
    .lo_wr_i(lo_wr), .eoi_valid_i, .eoi_level_i, .eoi_vec_i,
    .launch_i(launch), .svc_o(svc), .remote_o(remote)
  );

  irq_redir_out #(.NPINS(NPINS)) i_out (
    .clk_i, .rst_ni,
    .svc_i(svc), .mask_i(mask), .ent_i(ent), .ready_i(dlv_ready_i),
    .launch_o(launch), .valid_o(dlv_valid_o), .pin_o(dlv_pin_o), .ent_o(out_ent)
  );

  assign dlv_vec_o         = out_ent.vec;
  assign dlv_dest_o        = out_ent.dest;
  assign dlv_dst_logical_o = out_ent.dst_logical;
  assign dlv_dmode_o       = out_ent.dmode;
  assign dlv_level_o       = out_ent.level;

endmodule

// File: tb/test_irq_redir_router.sv
module test_irq_redir_router;

  localparam int NP = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [3:0]  reg_len = 4'd4;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] irq = '0;
  logic        eoi_valid = 1'b0, eoi_level = 1'b0;
  logic [7:0]  eoi_vec = '0;
  logic        dlv_valid, dlv_ready = 1'b1;
  logic [4:0]  dlv_pin;
  logic [7:0]  dlv_vec, dlv_dest;
  logic        dlv_logical, dlv_level;
  logic [2:0]  dlv_dmode;

  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  irq_redir_router i_irq_redir_router (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_len_i(reg_len),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_i(irq), .eoi_valid_i(eoi_valid), .eoi_level_i(eoi_level), .eoi_vec_i(eoi_vec),
    .dlv_valid_o(dlv_valid), .dlv_ready_i(dlv_ready), .dlv_pin_o(dlv_pin),
    .dlv_vec_o(dlv_vec), .dlv_dest_o(dlv_dest), .dlv_dst_logical_o(dlv_logical),
    .dlv_dmode_o(dlv_dmode), .dlv_level_o(dlv_level)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: got cycle %0d exp under 100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h exp %h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  function automatic logic [31:0] exp_lo(input logic [31:0] d, input logic rem);
    return (d & 32'h0001_AFFF) | (rem ? 32'h0000_4000 : 32'h0);
  endfunction

  function automatic logic [31:0] exp_hi(input logic [31:0] d);
    return d & 32'hFF00_0000;
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] len = 4'd4);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_len = len;
    @(posedge clk); #1;
    reg_req = 1'b0; reg_we = 1'b0; reg_len = 4'd4;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_req = 1'b0;
  endtask

  task automatic idx_rd(input logic [7:0] idx, output logic [31:0] d);
    bus_wr(8'h00, {24'h0, idx});
    bus_rd(8'h10, d);
  endtask

  task automatic set_lo(input int p, input logic [31:0] lo);
    bus_wr(8'h00, 32'(8'h10 + 2 * p));
    bus_wr(8'h10, lo);
  endtask

  task automatic set_hi(input int p, input logic [31:0] hi);
    bus_wr(8'h00, 32'(8'h11 + 2 * p));
    bus_wr(8'h10, hi);
  endtask

  task automatic wait_dlv(output bit got, output logic [4:0] pin);
    got = 1'b0; pin = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (dlv_valid) begin got = 1'b1; pin = dlv_pin; return; end
    end
  endtask

  task automatic quiet(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (dlv_valid) cnt++;
    end
  endtask

  task automatic eoi(input logic [7:0] v, input logic lvl);
    eoi_valid = 1'b1; eoi_vec = v; eoi_level = lvl;
    @(posedge clk); #1;
    eoi_valid = 1'b0;
  endtask

  task automatic expect_pin(input string req, input logic [4:0] p);
    bit got; logic [4:0] pin;
    wait_dlv(got, pin);
    chk(got && pin == p, req, {26'h0, got, pin}, {26'h0, 1'b1, p});
  endtask

  initial begin
    logic [31:0] d, lo, hi;
    int n, cnt;
    bit got;
    logic [4:0] pin;

    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R13 reset state
    bus_rd(8'h00, d);       chk_eq("R13 index", d, 32'h0);
    bus_rd(8'h10, d);       chk_eq("R13 id", d, 32'h0);
    chk_eq("R13 idle", {31'h0, dlv_valid}, 32'h0);
    idx_rd(8'h10, d);       chk_eq("R13 entry0 masked", d, 32'h0001_0000);
    idx_rd(8'h3E, d);       chk_eq("R13 entry23 masked", d, 32'h0001_0000);
    idx_rd(8'h3F, d);       chk_eq("R13 entry23 hi", d, 32'h0);

    // R2 version
    idx_rd(8'h01, d);       chk_eq("R2 version", d, 32'h0017_0011);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10, d);       chk_eq("R2 version ro", d, 32'h0017_0011);

    // R3 id and arbitration alias
    bus_wr(8'h00, 32'h0);
    bus_wr(8'h10, 32'hFA00_00FF);
    bus_rd(8'h10, d);       chk_eq("R3 id", d, 32'h0A00_0000);
    idx_rd(8'h02, d);       chk_eq("R3 arb alias", d, 32'h0A00_0000);
    bus_wr(8'h10, 32'h0500_0000);
    idx_rd(8'h00, d);       chk_eq("R3 arb write ignored", d, 32'h0A00_0000);

    // R1 window decoding and lengths
    bus_wr(8'h00, 32'h0000_0012);
    bus_wr(8'h00, 32'h0000_0014, 4'd2);
    bus_rd(8'h00, d);       chk_eq("R1 len2 ignored", d, 32'h12);
    bus_wr(8'h00, 32'h0000_0014, 4'd8);
    bus_rd(8'h00, d);       chk_eq("R1 len8 ok", d, 32'h14);
    bus_wr(8'h20, 32'h0000_0033);
    bus_rd(8'h20, d);       chk_eq("R1 other offset", d, 32'h0);
    bus_rd(8'h00, d);       chk_eq("R1 other offset write", d, 32'h14);

    // R4 random entry programming
    for (int k = 0; k < 40; k++) begin
      n  = $urandom_range(NP - 1, 0);
      lo = $urandom | 32'h0001_0000;
      hi = $urandom;
      set_hi(n, hi);
      set_lo(n, lo);
      idx_rd(8'(8'h10 + 2 * n), d); chk_eq("R4 lo readback", d, exp_lo(lo, 1'b0));
      idx_rd(8'(8'h11 + 2 * n), d); chk_eq("R4 hi readback", d, exp_hi(hi));
    end
    for (int p = 0; p < NP; p++) begin
      set_lo(p, 32'h0001_0000);
      set_hi(p, 32'h0);
    end
    set_lo(24, 32'h0000_00AB);
    bus_rd(8'h10, d);       chk_eq("R4 out of range read", d, 32'h0);
    idx_rd(8'h3E, d);       chk_eq("R4 oob no alias", d, 32'h0001_0000);
    chk_eq("R4 oob no delivery", {31'h0, dlv_valid}, 32'h0);

    // R6 R11 edge delivery and payload
    set_hi(3, 32'h5A00_0000);
    set_lo(3, 32'h0000_0933);
    quiet(5, cnt);          chk_eq("R6 no line no delivery", cnt, 0);
    irq[3] = 1'b1;
    wait_dlv(got, pin);
    chk(got && pin == 5'd3, "R6 edge pin", {27'h0, pin}, 32'd3);
    chk_eq("R11 payload", {dlv_vec, dlv_dest, 4'h0, dlv_logical, dlv_dmode, 7'h0, dlv_level},
           {8'h33, 8'h5A, 4'h0, 1'b1, 3'h1, 7'h0, 1'b0});
    quiet(20, cnt);         chk_eq("R6 held line once", cnt, 0);
    irq[3] = 1'b0;
    quiet(3, cnt);          chk_eq("R6 falling silent", cnt, 0);
    irq[3] = 1'b1;
    expect_pin("R6 second edge", 5'd3);
    irq[3] = 1'b0;
    set_lo(3, 32'h0001_0000);

    // R5 polarity
    set_lo(5, 32'h0000_2045);
    expect_pin("R5 inverted low line", 5'd5);
    irq[5] = 1'b1;
    quiet(5, cnt);          chk_eq("R5 request fall silent", cnt, 0);
    irq[5] = 1'b0;
    wait_dlv(got, pin);
    chk(got && pin == 5'd5 && dlv_vec == 8'h45, "R5 line fall delivers", {24'h0, dlv_vec}, 32'h45);
    set_lo(5, 32'h0001_2045);

    // R7 R9 level with remote pending
    set_lo(7, 32'h0000_8077);
    irq[7] = 1'b1;
    wait_dlv(got, pin);
    chk(got && pin == 5'd7 && dlv_level, "R7 level delivery", {27'h0, pin}, 32'd7);
    quiet(15, cnt);         chk_eq("R7 remote blocks", cnt, 0);
    idx_rd(8'h1E, d);       chk_eq("R7 remote bit set", d, 32'h0000_C077);
    eoi(8'h77, 1'b0);
    quiet(10, cnt);         chk_eq("R9 edge eoi no effect", cnt, 0);
    eoi(8'h78, 1'b1);
    quiet(10, cnt);         chk_eq("R9 other vector no effect", cnt, 0);
    eoi(8'h77, 1'b1);
    expect_pin("R9 eoi redelivers", 5'd7);

    // R10 half writes and remote
    set_hi(7, 32'h0100_0000);
    quiet(10, cnt);         chk_eq("R10 hi write keeps remote", cnt, 0);
    idx_rd(8'h1E, d);       chk_eq("R10 remote after hi", d, 32'h0000_C077);
    set_lo(7, 32'h0000_8077);
    expect_pin("R10 lo write clears remote", 5'd7);
    irq[7] = 1'b0;
    eoi(8'h77, 1'b1);
    quiet(10, cnt);         chk_eq("R9 inactive line not resent", cnt, 0);
    idx_rd(8'h1E, d);       chk_eq("R9 remote cleared", d, 32'h0000_8077);
    set_lo(7, 32'h0001_0000);

    // R8 masking
    set_lo(9, 32'h0001_8099);
    irq[9] = 1'b1;
    quiet(15, cnt);         chk_eq("R8 masked level silent", cnt, 0);
    set_lo(9, 32'h0000_8099);
    expect_pin("R8 unmask level delivers", 5'd9);
    set_lo(9, 32'h0001_0000);
    irq[9] = 1'b0;
    set_lo(10, 32'h0001_009A);
    irq[10] = 1'b1;
    quiet(10, cnt);         chk_eq("R8 masked edge silent", cnt, 0);
    set_lo(10, 32'h0000_009A);
    quiet(10, cnt);         chk_eq("R8 masked edge dropped", cnt, 0);
    irq[10] = 1'b0;
    set_lo(10, 32'h0001_0000);

    // R11 R12 R9 shared vector, stalled port
    set_lo(14, 32'h0000_8090);
    set_lo(12, 32'h0000_8090);
    dlv_ready = 1'b0;
    irq[14] = 1'b1; irq[12] = 1'b1;
    expect_pin("R12 lowest first", 5'd12);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(dlv_valid && dlv_pin == 5'd12 && dlv_vec == 8'h90, "R11 stall hold",
          {27'h0, dlv_pin}, 32'd12);
    end
    dlv_ready = 1'b1;
    expect_pin("R12 next pin", 5'd14);
    quiet(10, cnt);         chk_eq("R7 both pending", cnt, 0);
    eoi(8'h90, 1'b1);
    expect_pin("R9 shared eoi first", 5'd12);
    expect_pin("R9 shared eoi second", 5'd14);
    irq = '0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule